// File: doc/BRIEF.md
# Nibble-Bus SRAM Bridge

This block lets a host with very few spare pins reach a byte-wide static RAM. The host side is seven signals: a 4-bit shared address/data path and a 3-bit command code. The command is decoded each clock cycle into one of seven operations. A 16-bit address is built up in a loadable counter, one 4-bit slice per load command. Write data is gathered a nibble at a time into a holding latch. Read data comes back one nibble at a time through a half-byte selector.

The address counter steps by one after every completed byte write and after the second nibble of every read. A block of consecutive bytes can therefore be streamed without reloading the address. On the memory side the block presents the address, the write byte together with its drive enable, a single-cycle write strobe and an output enable, and it takes the read byte back.

The host path is split into an input, an output and an output enable, so the pad tristate sits outside the block. The block only drives the path while a read command is present.

Top module: `nib_sram_bridge`

## Requirements
- R1: A synchronous active-high reset clears the address to 0x0000, the write holding latches, the write sequence and the read nibble select. Afterwards `mem_we`, `mem_wdrv`, `mem_oe` and `hbus_oe` are all 0.
- R2: Command codes 3'b001, 3'b010, 3'b011 and 3'b100 load `hbus_in` into address bits [3:0], [7:4], [11:8] and [15:12] respectively. The load takes effect on the clock edge that samples the command.
- R3: Code 3'b101 captures `hbus_in` as the low write nibble. Code 3'b110 captures `hbus_in` as the high nibble and starts a write of the byte {high, low}.
- R4: A write keeps `mem_wdrv` at 1 for two cycles. In the first cycle `mem_we` is 0. In the second cycle `mem_we` is 1 while address and data are unchanged. On the edge that ends the strobe, `mem_we` returns to 0 and the address advances by one.
- R5: Code 3'b111 reads. The host path carries `mem_rdata[3:0]` when the nibble select is 0 and `mem_rdata[7:4]` when it is 1. Each read toggles the select, and the address advances by one on the read that returns the high nibble.
- R6: `hbus_oe` and `mem_oe` are 1 only while code 3'b111 is present and no write is in progress. `mem_oe` and `mem_wdrv` are never 1 together.
- R7: Every address increment wraps from 0xFFFF to 0x0000.
- R8: Any command presented during the two cycles of a write is ignored: no load, no latch, no read and no bus drive.
- R9: Every address-load command returns the read nibble select to the low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Host command code |
| hbus_in | input | 4 | Host nibble path, host to block |
| hbus_out | output | 4 | Host nibble path, block to host |
| hbus_oe | output | 1 | Block drives the host nibble path |
| mem_addr | output | 16 | SRAM address |
| mem_wdata | output | 8 | SRAM write byte |
| mem_wdrv | output | 1 | Drive enable for the SRAM data lines |
| mem_we | output | 1 | SRAM write strobe, one cycle |
| mem_oe | output | 1 | SRAM output enable |
| mem_rdata | input | 8 | SRAM read byte |

## Verification
The bench builds the block with its defaults: 4-bit nibbles and four address slices, which gives a 16-bit address. Because any address can be loaded in four commands, the carry ripple across all four slices and the wrap from 0xFFFF to 0x0000 are easy to reach after both writes and reads. Commands are also issued while a write is in progress, and reset is applied with the read select set to the high nibble, to cover the ignore and clear paths.

// File: rtl/nib_sram_bridge.sv
module nib_sram_bridge #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 4,
  localparam int ADDR_W   = NIB_W * ADDR_NIBS,
  localparam int DATA_W   = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [NIB_W-1:0]  hbus_in,
  output logic [NIB_W-1:0]  hbus_out,
  output logic              hbus_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdrv,
  output logic              mem_we,
  output logic              mem_oe,
  input  logic [DATA_W-1:0] mem_rdata
);

  typedef enum logic [1:0] {W_IDLE, W_SETUP, W_STROBE} wph_t;

  wph_t             wph;
  logic             busy;
  logic [7:1]       op;
  logic             any_load;
  logic             rd_sel;
  logic             inc;
  logic [NIB_W-1:0] wlo, whi;
  logic [ADDR_NIBS-1:0] cy;

  assign busy = (wph != W_IDLE);

  for (genvar k = 1; k < 8; k++) begin : g_dec
    assign op[k] = !busy && (cmd == 3'(k));
  end

  assign any_load = |op[ADDR_NIBS:1];
  assign inc      = (wph == W_STROBE) || (op[7] && rd_sel);
  assign cy[0]    = inc;

  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_slice
    logic [NIB_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)            cnt <= '0;
      else if (op[g+1])   cnt <= hbus_in;
      else if (cy[g])     cnt <= cnt + 1'b1;
    end
    if (g < ADDR_NIBS-1) begin : g_carry
      assign cy[g+1] = cy[g] && (&cnt);
    end
    assign mem_addr[g*NIB_W +: NIB_W] = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wph    <= W_IDLE;
      wlo    <= '0;
      whi    <= '0;
      rd_sel <= 1'b0;
    end else begin
      case (wph)
        W_IDLE:   if (op[6]) begin
                    whi <= hbus_in;
                    wph <= W_SETUP;
                  end
        W_SETUP:  wph <= W_STROBE;
        W_STROBE: wph <= W_IDLE;
        default:  wph <= W_IDLE;
      endcase
      if (op[5]) wlo <= hbus_in;
      if (any_load)   rd_sel <= 1'b0;
      else if (op[7]) rd_sel <= !rd_sel;
    end
  end

  assign hbus_oe   = op[7];
  assign mem_oe    = op[7];
  assign hbus_out  = rd_sel ? mem_rdata[DATA_W-1:NIB_W] : mem_rdata[NIB_W-1:0];
  assign mem_wdata = {whi, wlo};
  assign mem_wdrv  = busy;
  assign mem_we    = (wph == W_STROBE);

endmodule

module nib_sram_bridge_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd,
  input logic [NW-1:0] hbus_in,
  input logic          hbus_oe,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic          mem_wdrv,
  input logic          mem_oe,
  input logic          busy
);

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4

  AST_WE_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($stable(mem_addr) && $stable(mem_wdata) && $past(mem_wdrv))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R7

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    hbus_oe |-> (cmd == 3'b111 && !busy)); // R6

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(mem_oe && mem_wdrv)); // R6

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd) == 3'b001 && !$past(busy)) |-> (mem_addr[NW-1:0] == $past(hbus_in))); // R2

endmodule

bind nib_sram_bridge nib_sram_bridge_chk #(.AW(ADDR_W), .DW(DATA_W), .NW(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .hbus_in(hbus_in), .hbus_oe(hbus_oe),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .mem_wdrv(mem_wdrv), .mem_oe(mem_oe), .busy(busy)
);

// File: tb/nib_sram_bridge_tb.sv
`timescale 1ns/1ps
module nib_sram_bridge_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'b000;
  logic [3:0]  din = 4'h0;
  logic [3:0]  hbus_out;
  logic        hbus_oe;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wdrv, mem_we, mem_oe;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem [1024];

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  nib_sram_bridge u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .hbus_in(din),
    .hbus_out(hbus_out), .hbus_oe(hbus_oe), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdrv(mem_wdrv), .mem_we(mem_we),
    .mem_oe(mem_oe), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[9:0]];

  // {cmd, din, check bus, expected bus nibble, expected address afterwards}
  localparam logic [27:0] VEC [14] = '{
    {3'b001, 4'h4, 1'b0, 4'h0, 16'h0004},
    {3'b010, 4'h2, 1'b0, 4'h0, 16'h0024},
    {3'b011, 4'h0, 1'b0, 4'h0, 16'h0024},
    {3'b100, 4'h0, 1'b0, 4'h0, 16'h0024},
    {3'b101, 4'hA, 1'b0, 4'h0, 16'h0024},
    {3'b110, 4'h5, 1'b0, 4'h0, 16'h0025},
    {3'b101, 4'h3, 1'b0, 4'h0, 16'h0025},
    {3'b110, 4'hC, 1'b0, 4'h0, 16'h0026},
    {3'b001, 4'h4, 1'b0, 4'h0, 16'h0024},
    {3'b111, 4'h0, 1'b1, 4'hA, 16'h0024},
    {3'b111, 4'h0, 1'b1, 4'h5, 16'h0025},
    {3'b111, 4'h0, 1'b1, 4'h3, 16'h0025},
    {3'b111, 4'h0, 1'b1, 4'hC, 16'h0026},
    {3'b000, 4'h0, 1'b0, 4'h0, 16'h0026}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] c, input logic [3:0] d,
                    output logic oe, output logic [3:0] bo);
    cmd = c; din = d;
    #1;
    oe = hbus_oe; bo = hbus_out;
    @(negedge clk);
    cmd = 3'b000;
    if (c == 3'b110) repeat (2) @(negedge clk);
  endtask

  task automatic load_addr(input logic [15:0] a);
    logic oe; logic [3:0] bo;
    op(3'b001, a[3:0], oe, bo);
    op(3'b010, a[7:4], oe, bo);
    op(3'b011, a[11:8], oe, bo);
    op(3'b100, a[15:12], oe, bo);
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog expired actual=0 expected=1");
    fails++;
    tests++;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic oe; logic [3:0] bo;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[0] = 8'hB4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(mem_addr == 16'h0000, "R1 addr", mem_addr, 0);
    check(!mem_we && !mem_wdrv && !mem_oe && !hbus_oe, "R1 strobes",
          {mem_we, mem_wdrv, mem_oe, hbus_oe}, 0);

    // Table walk: R2 loads, R3 latches, R5 reads
    for (int i = 0; i < 14; i++) begin
      logic [27:0] v;
      v = VEC[i];
      op(v[27:25], v[24:21], oe, bo);
      if (v[20]) check(oe && bo == v[19:16], "R5 read nibble", {oe, bo}, {1'b1, v[19:16]});
      else       check(!oe, "R6 bus released", oe, 0);
      check(mem_addr == v[15:0], "R2 address after step", mem_addr, v[15:0]);
    end
    check(mem[10'h24] == 8'h5A && mem[10'h25] == 8'hC3, "R3 stored bytes",
          {mem[10'h24], mem[10'h25]}, 16'h5AC3);

    // R4 write strobe timing
    load_addr(16'h0040);
    op(3'b101, 4'h9, oe, bo);
    cmd = 3'b110; din = 4'h6;
    @(negedge clk); cmd = 3'b000;
    check(mem_wdrv && !mem_we && mem_wdata == 8'h69, "R4 setup cycle",
          {mem_wdrv, mem_we, mem_wdata}, {2'b10, 8'h69});
    @(negedge clk);
    check(mem_we && mem_addr == 16'h0040 && mem_wdata == 8'h69, "R4 strobe cycle",
          {mem_we, mem_addr}, {1'b1, 16'h0040});
    @(negedge clk);
    check(!mem_we && !mem_wdrv && mem_addr == 16'h0041, "R4 strobe end",
          {mem_we, mem_wdrv, mem_addr}, {2'b00, 16'h0041});

    // R7 wrap on write
    load_addr(16'hFFFF);
    op(3'b101, 4'h1, oe, bo);
    op(3'b110, 4'h2, oe, bo);
    check(mem_addr == 16'h0000, "R7 write wrap", mem_addr, 0);
    check(mem[10'h3FF] == 8'h21, "R3 wrap byte", mem[10'h3FF], 8'h21);
    // R7 wrap on read
    load_addr(16'hFFFF);
    op(3'b111, 4'h0, oe, bo);
    check(bo == 4'h1 && mem_addr == 16'hFFFF, "R5 low nibble no step", {bo, mem_addr}, {4'h1, 16'hFFFF});
    op(3'b111, 4'h0, oe, bo);
    check(bo == 4'h2 && mem_addr == 16'h0000, "R7 read wrap", {bo, mem_addr}, {4'h2, 16'h0000});

    // R8 commands during a write are ignored
    load_addr(16'h0030);
    op(3'b101, 4'h7, oe, bo);
    cmd = 3'b110; din = 4'h8;
    @(negedge clk);
    cmd = 3'b001; din = 4'hF;
    @(negedge clk);
    cmd = 3'b111; din = 4'h0;
    #1;
    check(!hbus_oe && !mem_oe, "R8 read ignored while busy", {hbus_oe, mem_oe}, 0);
    @(negedge clk);
    cmd = 3'b000;
    check(mem_addr == 16'h0031, "R8 load ignored while busy", mem_addr, 16'h0031);
    op(3'b001, 4'h0, oe, bo);
    op(3'b111, 4'h0, oe, bo);
    check(bo == 4'h7, "R3 low nibble stored", bo, 4'h7);

    // R9 load resets nibble select
    op(3'b001, 4'h0, oe, bo);
    op(3'b111, 4'h0, oe, bo);
    check(bo == 4'h7, "R9 select after load", bo, 4'h7);

    // R1 reset clears select mid-read
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(mem_addr == 16'h0000, "R1 addr after reset", mem_addr, 0);
    op(3'b111, 4'h0, oe, bo);
    check(oe && bo == 4'h4, "R1 select cleared", {oe, bo}, {1'b1, 4'h4});
    op(3'b111, 4'h0, oe, bo);
    check(bo == 4'hB && mem_addr == 16'h0001, "R5 high nibble then step", {bo, mem_addr}, {4'hB, 16'h0001});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule